// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Restart

This block guards a system against software that stops servicing it. A slow input clock is divided by a programmable prescaler into a tick. Each tick moves a down-counter one step toward zero. When the counter is ticked while at zero, the watchdog records an underflow and can request a system reset. Software keeps the system alive by writing a restart command that carries an 8-bit key. A restart is legal only while the counter has already fallen to or below a programmed window limit. A restart that arrives too early counts as a fault, in the same way as a missed restart.

All configuration lives in one mode word, and that word accepts a single write after reset. A stray or hostile write cannot later weaken the protection. Out of reset the block already runs with the longest period and reset requests enabled, so an unconfigured system is still protected. Everything runs in the slow clock domain. A restart command is held pending and takes effect on the next tick.

Top module: `wdog_window`

## Requirements
- R1: After reset the count reads 0xFFF and the status reads 0. The mode word reads 0x0FFF_1FFF. Its fields are: reload in bits 11:0, reset-enable in bit 12, halt-enable in bit 13, disable in bit 14, window limit in bits 27:16.
- R2: A tick occurs once every PRESC_DIV clocks, and each tick lowers the count by one. A tick at count 0 is an expiry, and it reloads the counter. Consecutive expiries are therefore (reload+1)*PRESC_DIV clocks apart.
- R3: An expiry sets status bit 0 (address 2). The bit stays set until status is read, and that read clears it. wd_irq_o is high while any status bit is set.
- R4: An expiry or window violation with reset-enable set drives wd_rst_req_o high for exactly one clock. With reset-enable clear, no request is made.
- R5: The mode word at address 1 takes only the first write after reset. Later writes leave it unchanged.
- R6: A write to address 0 with bit 0 set and bits 31:24 equal to 0xA5 requests a restart. The request is applied at the next tick and reloads the counter.
- R7: A control write with a different key, or with bit 0 clear, has no effect on the count.
- R8: A restart applied while the count is above the window limit sets status bit 1, raises a reset request if enabled, and reloads the counter. A restart at or below the limit sets no status bit and raises no request. A limit of 0xFFF admits a restart at any count.
- R9: With the disable bit set, the count holds and no status bit or reset request arises. The mode readback shows the bit.
- R10: With halt-enable set, the count holds while dbg_halt_i is high. With halt-enable clear, dbg_halt_i is ignored.
- R11: bus_ready is always 1, and address 3 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, the only clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt_i | input | 1 | Debugger halt indication |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (clears status on read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| bus_ready | output | 1 | Always high |
| wd_irq_o | output | 1 | High while a status flag is set |
| wd_rst_req_o | output | 1 | One-clock reset request |

## Verification
The bench programs a table of reload values from 0 to 100 and measures the clock distance between consecutive reset requests. This separates an off-by-one in the expiry point from one in the prescaler. Restarts are tried with the correct key, with a wrong key, and with the command bit clear, which shows that only the exact key/bit pairing reloads. With a narrow window, one restart is issued above the limit and one below it, which shows that the comparison picks the violation path only for early restarts. Disable, halt with and without the halt-enable bit, and a second mode write check that these controls freeze or lock only what they should.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      A_CTRL  = 2'd0,
      A_MODE  = 2'd1,
      A_STAT  = 2'd2,
      A_COUNT = 2'd3
   } wd_addr_e;

   localparam int unsigned BUS_W       = 32;
   localparam int unsigned KEY_W       = 8;
   localparam int unsigned KEY_LSB     = 24;
   localparam int unsigned BIT_RESTART = 0;
   localparam int unsigned BIT_RSTEN   = 12;
   localparam int unsigned BIT_DBGEN   = 13;
   localparam int unsigned BIT_DIS     = 14;
   localparam int unsigned WIN_LSB     = 16;
   localparam int unsigned ST_UF       = 0;
   localparam int unsigned ST_ERR      = 1;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned DIV = 128
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int unsigned PW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit          POW2 = ((DIV & (DIV - 1)) == 0);

   logic [PW-1:0] phase_q;

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     phase_q <= '0;
            else if (run_i) phase_q <= phase_q + 1'b1;
         end
         assign tick_o = run_i && (&phase_q);
      end else begin : g_mod
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     phase_q <= '0;
            else if (run_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
         end
         assign tick_o = run_i && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int unsigned CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic [CNT_W-1:0] window_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o,
   output logic             violate_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             legal, take;

   assign legal     = (cnt_q <= window_i);
   assign take      = tick_i && pend_q && legal;
   assign violate_o = tick_i && pend_q && !legal;
   assign expire_o  = tick_i && !pend_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '1;
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q && !tick_i) || restart_i;
         if (take || violate_o || expire_o) cnt_q <= reload_i;
         else if (tick_i)                   cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W = 12,
   parameter logic [KEY_W-1:0] RESTART_KEY = 8'hA5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic             re_i,
   input  logic [1:0]       addr_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             uf_set_i,
   input  logic             err_set_i,
   output logic [BUS_W-1:0] rdata_o,
   output logic [BUS_W-1:0] mode_o,
   output logic [CNT_W-1:0] reload_o,
   output logic [CNT_W-1:0] window_o,
   output logic             rsten_o,
   output logic             dbgen_o,
   output logic             dis_o,
   output logic             locked_o,
   output logic             restart_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] reload_q, window_q;
   logic             rsten_q, dbgen_q, dis_q, locked_q;
   logic [1:0]       stat_q;
   logic             mode_wr, stat_rd;
   logic             unused_wbits;

   assign mode_wr = we_i && (addr_i == A_MODE) && !locked_q;
   assign stat_rd = re_i && (addr_i == A_STAT);
   assign unused_wbits = ^wdata_i;

   assign restart_o = we_i && (addr_i == A_CTRL)
                      && (wdata_i[KEY_LSB +: KEY_W] == RESTART_KEY)
                      && wdata_i[BIT_RESTART];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         window_q <= '1;
         rsten_q  <= 1'b1;
         dbgen_q  <= 1'b0;
         dis_q    <= 1'b0;
         locked_q <= 1'b0;
      end else if (mode_wr) begin
         reload_q <= wdata_i[CNT_W-1:0];
         window_q <= wdata_i[WIN_LSB +: CNT_W];
         rsten_q  <= wdata_i[BIT_RSTEN];
         dbgen_q  <= wdata_i[BIT_DBGEN];
         dis_q    <= wdata_i[BIT_DIS];
         locked_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else begin
         stat_q[ST_UF]  <= uf_set_i  || (stat_q[ST_UF]  && !stat_rd);
         stat_q[ST_ERR] <= err_set_i || (stat_q[ST_ERR] && !stat_rd);
      end
   end

   always_comb begin
      mode_o                   = '0;
      mode_o[CNT_W-1:0]        = reload_q;
      mode_o[BIT_RSTEN]        = rsten_q;
      mode_o[BIT_DBGEN]        = dbgen_q;
      mode_o[BIT_DIS]          = dis_q;
      mode_o[WIN_LSB +: CNT_W] = window_q;
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_MODE:  rdata_o = mode_o;
         A_STAT:  rdata_o[1:0] = stat_q;
         A_COUNT: rdata_o[CNT_W-1:0] = cnt_i;
         default: rdata_o = '0;
      endcase
   end

   assign reload_o = reload_q;
   assign window_o = window_q;
   assign rsten_o  = rsten_q;
   assign dbgen_o  = dbgen_q;
   assign dis_o    = dis_q;
   assign locked_o = locked_q;
   assign irq_o    = |stat_q;
endmodule

// File: rtl/wdog_window.sv
module wdog_window
   import wdog_pkg::*;
#(
   parameter int unsigned      CNT_W       = 12,
   parameter int unsigned      PRESC_DIV   = 128,
   parameter logic [KEY_W-1:0] RESTART_KEY = 8'hA5
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dbg_halt_i,
   input  logic        bus_we,
   input  logic        bus_re,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        bus_ready,
   output logic        wd_irq_o,
   output logic        wd_rst_req_o
);
   if (CNT_W < 4 || CNT_W > 12) begin : g_bad_cnt_w
      $error("wdog_window: CNT_W must lie in 4..12 to fit the mode word");
   end
   if (PRESC_DIV < 2) begin : g_bad_div
      $error("wdog_window: PRESC_DIV must be at least 2");
   end

   logic [CNT_W-1:0] reload, window, cnt;
   logic [BUS_W-1:0] mode_word;
   logic             rsten, dbgen, dis, locked;
   logic             restart_cmd, run, tick, expire, violate;
   logic             rst_req_q;

   assign run = !dis && !(dbgen && dbg_halt_i);

   wdog_regs #(.CNT_W(CNT_W), .RESTART_KEY(RESTART_KEY)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (bus_we),
      .re_i      (bus_re),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .cnt_i     (cnt),
      .uf_set_i  (expire),
      .err_set_i (violate),
      .rdata_o   (bus_rdata),
      .mode_o    (mode_word),
      .reload_o  (reload),
      .window_o  (window),
      .rsten_o   (rsten),
      .dbgen_o   (dbgen),
      .dis_o     (dis),
      .locked_o  (locked),
      .restart_o (restart_cmd),
      .irq_o     (wd_irq_o)
   );

   wdog_prescaler #(.DIV(PRESC_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   wdog_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .restart_i (restart_cmd),
      .reload_i  (reload),
      .window_i  (window),
      .cnt_o     (cnt),
      .expire_o  (expire),
      .violate_o (violate)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= rsten && (expire || violate);
   end

   assign wd_rst_req_o = rst_req_q;
   assign bus_ready    = 1'b1;
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
   parameter int unsigned CNT_W = 12
)(
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic [31:0]      mode_word,
   input logic             locked,
   input logic             dis,
   input logic             dbgen,
   input logic             dbg_halt_i,
   input logic             rst_req
);
   logic past_v;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_v <= 1'b0;
      else        past_v <= 1'b1;
   end

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r2_step_or_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (past_v && (cnt != $past(cnt))) |->
         ((cnt == $past(cnt) - 1'b1) || (cnt == reload)));

   a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode_word));

   a_r9_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      dis |=> ($stable(cnt) && !rst_req));

   a_r10_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (dbgen && dbg_halt_i) |=> $stable(cnt));
endmodule

bind wdog_window wdog_window_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt        (cnt),
   .reload     (reload),
   .mode_word  (mode_word),
   .locked     (locked),
   .dis        (dis),
   .dbgen      (dbgen),
   .dbg_halt_i (dbg_halt_i),
   .rst_req    (wd_rst_req_o)
);

// File: tb/sim_wdog_window.sv
module sim_wdog_window;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_halt_i = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready, wd_irq_o, wd_rst_req_o;

   int n_chk = 0;
   int n_fail = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdog_window #(.CNT_W(12), .PRESC_DIV(DIV), .RESTART_KEY(8'hA5)) u0 (
      .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt_i),
      .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .wd_irq_o(wd_irq_o), .wd_rst_req_o(wd_rst_req_o));

   always @(negedge clk) if (wd_rst_req_o) pulses++;

   localparam int NV = 5;
   localparam logic [11:0] V_RLD [NV] = '{12'd0, 12'd1, 12'd7, 12'd30, 12'd100};
   localparam int          V_PER [NV] = '{4, 8, 32, 124, 404};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pulses = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_re = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] d, c1, c2, c3, c4;
      int per;

      // Reset state (R1, R11)
      do_reset();
      rd(2'd1, d); chk("R1 mode reset value", d, 32'h0FFF_1FFF);
      rd(2'd3, d); chk("R1 count reset value", d, 32'h0000_0FFF);
      rd(2'd2, d); chk("R1 status reset value", d, 32'h0);
      chk("R11 ready high", {31'b0, bus_ready}, 32'h1);
      chk("R3 irq low after reset", {31'b0, wd_irq_o}, 32'h0);

      // Tick rate; halt input ignored while halt-enable clear (R2, R10)
      dbg_halt_i = 1'b1;
      rd(2'd3, c1);
      wait_cyc(39);
      rd(2'd3, c2);
      dbg_halt_i = 1'b0;
      chk("R2 R10 ten ticks in forty clocks", c1 - c2, 32'd10);

      // Vector table: expiry period per reload value (R2, R4)
      for (int i = 0; i < NV; i++) begin
         do_reset();
         wr(2'd1, 32'h0FFF_1000 | {20'b0, V_RLD[i]});
         wr(2'd0, 32'hA500_0001);
         while (wd_rst_req_o !== 1'b1) @(negedge clk);
         per = 0;
         do begin
            @(negedge clk);
            per++;
         end while (wd_rst_req_o !== 1'b1);
         chk($sformatf("R2 R4 period for reload %0d", V_RLD[i]), per, V_PER[i]);
      end

      // Write-once mode (R5); state left locked with reload 100
      wr(2'd1, 32'h0000_4005);
      rd(2'd1, d); chk("R5 second mode write ignored", d, 32'h0FFF_1064);

      // Reset-enable clear, sticky clear-on-read underflow (R3, R4)
      do_reset();
      wr(2'd1, 32'h0FFF_000A);
      wr(2'd0, 32'hA500_0001);
      wait_cyc(58);
      chk("R3 irq high after expiry", {31'b0, wd_irq_o}, 32'h1);
      rd(2'd2, d); chk("R3 underflow flag set", d, 32'h1);
      rd(2'd2, d); chk("R3 underflow cleared by read", d, 32'h0);
      chk("R3 irq low after clear", {31'b0, wd_irq_o}, 32'h0);
      chk("R4 no request with reset-enable clear", pulses, 32'd0);

      // Key handling (R6, R7)
      do_reset();
      wr(2'd1, 32'h0FFF_10C8);
      wr(2'd0, 32'hA500_0001);
      wait_cyc(40);
      rd(2'd3, c1);
      wr(2'd0, 32'h5A00_0001);
      wait_cyc(20);
      rd(2'd3, c2);
      chk("R7 wrong key ignored", {31'b0, (c2 < c1)}, 32'h1);
      wr(2'd0, 32'hA500_0000);
      wait_cyc(20);
      rd(2'd3, c3);
      chk("R7 restart bit clear ignored", {31'b0, (c3 < c2)}, 32'h1);
      wr(2'd0, 32'hA500_0001);
      wait_cyc(12);
      rd(2'd3, c4);
      chk("R6 keyed restart reloads", {31'b0, (c4 >= 32'd197 && c4 <= 32'd200)}, 32'h1);

      // Window (R8)
      do_reset();
      wr(2'd1, 32'h000A_1028);
      wr(2'd0, 32'hA500_0001);
      wait_cyc(12);
      rd(2'd3, c1);
      chk("R8 early restart reloads", {31'b0, (c1 >= 32'd37 && c1 <= 32'd40)}, 32'h1);
      rd(2'd2, d); chk("R8 early restart sets error flag", d, 32'h2);
      chk("R8 early restart requests reset", pulses, 32'd1);
      rd(2'd3, c1);
      while (c1 > 32'd8) rd(2'd3, c1);
      wr(2'd0, 32'hA500_0001);
      wait_cyc(12);
      rd(2'd3, c2);
      chk("R8 in-window restart reloads", {31'b0, (c2 >= 32'd37)}, 32'h1);
      rd(2'd2, d); chk("R8 in-window restart no flag", d, 32'h0);
      chk("R8 in-window restart no request", pulses, 32'd1);

      // Disable (R9)
      do_reset();
      wr(2'd1, 32'h0FFF_5FFF);
      rd(2'd1, d); chk("R9 disable bit readback", d, 32'h0FFF_5FFF);
      rd(2'd3, c1);
      wait_cyc(100);
      rd(2'd3, c2);
      chk("R9 count frozen when disabled", c2, c1);
      rd(2'd2, d); chk("R9 no status when disabled", d, 32'h0);
      chk("R9 no request when disabled", pulses, 32'd0);

      // Halt with halt-enable set (R10)
      do_reset();
      wr(2'd1, 32'h0FFF_3FFF);
      dbg_halt_i = 1'b1;
      rd(2'd3, c1);
      wait_cyc(40);
      rd(2'd3, c2);
      dbg_halt_i = 1'b0;
      chk("R10 count frozen during halt", c2, c1);
      wait_cyc(38);
      rd(2'd3, c3);
      chk("R10 count resumes after halt", {31'b0, (c3 < c2 && (c2 - c3) <= 32'd10)}, 32'h1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements) actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule